// File: doc/BRIEF.md
# ARX Matrix Hash Compression Core

This block runs one compression step of a 256-bit-digest hash. The caller supplies a 256-bit chaining value, a 512-bit message block, a 64-bit bit counter and a 128-bit salt. The core loads a 4×4 matrix of 32-bit words from them and runs a fixed number of rounds. Each round is built only from 32-bit modular addition, XOR and fixed right rotations. The core then folds the matrix back into a new 256-bit chaining value. Padding, chaining across several blocks and truncation of the digest to shorter lengths are handled by the surrounding logic.

The input side is a valid/ready stream. A job is taken on a clock edge where `in_valid` and `in_ready` are both high. The source must hold its data stable only until that edge, because the core registers all inputs when it accepts a job. `in_ready` stays low for the whole computation, so the source sees back-pressure for exactly one job at a time. The result side has no back-pressure. `done` is a one-cycle pulse, and `digest` holds its value until the next job completes. A new job can be accepted in the same cycle that `done` is high.

Every word field is little-endian by word. Word i of a field lies at bits [32·i+31 : 32·i].

Top module: `arx_cmp_top`

## Requirements
- R1: After reset, `in_ready` is 1, `done` is 0 and `digest` is all zeros.
- R2: A job is accepted only when `in_valid` and `in_ready` are both high at a clock edge. After acceptance `in_ready` is 0 until the job completes. `in_valid` and the data buses have no effect while `in_ready` is 0.
- R3: `done` is high for exactly one cycle. It is sampled high at the edge 2·ROUNDS+1 cycles after the accepting edge, which is 29 cycles with the default of 14 rounds. `in_ready` is high again in that same cycle.
- R4: State setup: words 0–7 take chain words 0–7, and words 8–11 take salt words 0–3 XOR constants K0–K3. Words 12 and 13 take counter low word XOR K4 and K5. Words 14 and 15 take counter high word XOR K6 and K7. K0..K15 are the fixed constants 243F6A88, 85A308D3, 13198A2E, 03707344, A4093822, 299F31D0, 082EFA98, EC4E6C89, 452821E6, 38D01377, BE5466CF, 34E90C6C, C0AC29B7, C97C50DD, 3F84D5B5, B5470917 (hex).
- R5: The mixer on words (a,b,c,d) with inputs x,y works in order. First a=a+b+x, d=(d^a)>>>16, c=c+d, b=(b^c)>>>12. Then a=a+b+y, d=(d^a)>>>8, c=c+d, b=(b^c)>>>7. Here >>> is a 32-bit right rotation.
- R6: Each round first mixes the four columns (j, 4+j, 8+j, 12+j) as mixers 0–3. It then mixes the four diagonals (0,5,10,15), (1,6,11,12), (2,7,8,13), (3,4,9,14) as mixers 4–7.
- R7: Mixer i in round r uses p=S[r mod 10][2i] and q=S[r mod 10][2i+1], with x = M[p]^K[q] and y = M[q]^K[p]. S is a fixed ten-row table of permutations of 0..15, and row 0 is the identity. Rounds 10–13 reuse rows 0–3.
- R8: Output word i (0–7) equals old chain word i XOR salt word (i mod 4) XOR state word i XOR state word i+8.
- R9: `digest` does not change except in the cycle where `done` is high.
- R10: A chain of the standard 256-bit initial words, a block encoding one zero byte (word0=00800000, word13=00000001, word15=00000008, others 0), counter 8 and salt 0 gives the digest words 0CE8D4EF 4DD7CD8D 62DFDED9 D4EDB0A7 74AE6A41 929A74DA 23109E8F 11139C87 as words 0 to 7.
- R11: Jobs offered back to back are each accepted in the first cycle `in_ready` is high. Each produces its own digest in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Job offered on the data buses |
| in_ready | output | 1 | Core is idle and will take a job |
| chain_in | input | 256 | Chaining value, eight words |
| block_in | input | 512 | Message block, sixteen words |
| count_in | input | 64 | Bit counter, low word in bits 31:0 |
| salt_in | input | 128 | Salt, four words |
| done | output | 1 | One-cycle pulse, digest just updated |
| digest | output | 256 | New chaining value, eight words |

## Verification
The hardest thing to reach from the ports is a wrong message-schedule row in rounds 10 to 13, where the row index wraps. It only changes the final XOR-folded words and never the timing. It is also easy to miss if the reference shares the same mistake. The bench drives each job against a cycle-free reference model written from the requirements. It also anchors that model to the fixed known-answer digest. It then drives random chains, blocks, salts and counters with both counter words non-zero, so every setup constant and every schedule row affects the result. Separate sequences hold `in_valid` high with unrelated data during a busy period and offer jobs back to back, which checks acceptance timing and that the data is ignored.

// File: rtl/arx_pkg.sv
package arx_pkg;
  localparam int WORD_W     = 32;
  localparam int NWORDS     = 16;
  localparam int LANES      = 4;
  localparam int CHAIN_W    = 8;
  localparam int SALT_W     = 4;
  localparam int SCHED_ROWS = 10;

  typedef logic [WORD_W-1:0] word_t;
  typedef word_t [NWORDS-1:0] state_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_FIN} seq_state_e;

  // fixed mixing constants
  function automatic word_t arx_const(input logic [3:0] idx);
    word_t k;
    case (idx)
      4'd0:  k = 32'h243F6A88;
      4'd1:  k = 32'h85A308D3;
      4'd2:  k = 32'h13198A2E;
      4'd3:  k = 32'h03707344;
      4'd4:  k = 32'hA4093822;
      4'd5:  k = 32'h299F31D0;
      4'd6:  k = 32'h082EFA98;
      4'd7:  k = 32'hEC4E6C89;
      4'd8:  k = 32'h452821E6;
      4'd9:  k = 32'h38D01377;
      4'd10: k = 32'hBE5466CF;
      4'd11: k = 32'h34E90C6C;
      4'd12: k = 32'hC0AC29B7;
      4'd13: k = 32'hC97C50DD;
      4'd14: k = 32'h3F84D5B5;
      default: k = 32'hB5470917;
    endcase
    return k;
  endfunction

  // message schedule rows, sixteen nibbles each, position 0 in the top nibble
  function automatic logic [63:0] arx_sched_row(input logic [3:0] row);
    logic [63:0] r;
    case (row)
      4'd0: r = 64'h0123456789ABCDEF;
      4'd1: r = 64'hEA489FD61C02B753;
      4'd2: r = 64'hB8C052FDAE367194;
      4'd3: r = 64'h7931DCBE265A40F8;
      4'd4: r = 64'h905724AFE1BC683D;
      4'd5: r = 64'h2C6A0B834D75FE19;
      4'd6: r = 64'hC51FED4A0763928B;
      4'd7: r = 64'hDB7EC13950F4862A;
      4'd8: r = 64'h6FE9B308C2D714A5;
      default: r = 64'hA2847615FB9E3CD0;
    endcase
    return r;
  endfunction

  function automatic logic [3:0] arx_sched_pick(input logic [3:0] row, input logic [3:0] pos);
    logic [63:0] r;
    int p;
    r = arx_sched_row(row);
    p = 15 - int'(pos);
    return r[p*4 +: 4];
  endfunction

  function automatic word_t arx_rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction
endpackage

// File: rtl/arx_g_mix.sv
module arx_g_mix
  import arx_pkg::*;
#(
  parameter int ROT_A = 16,
  parameter int ROT_B = 12,
  parameter int ROT_C = 8,
  parameter int ROT_D = 7
) (
  input  word_t a_i,
  input  word_t b_i,
  input  word_t c_i,
  input  word_t d_i,
  input  word_t k0_i,
  input  word_t k1_i,
  output word_t a_o,
  output word_t b_o,
  output word_t c_o,
  output word_t d_o
);
  word_t a1, b1, c1, d1;

  always_comb begin
    a1  = a_i + b_i + k0_i;
    d1  = arx_rotr(d_i ^ a1, ROT_A);
    c1  = c_i + d1;
    b1  = arx_rotr(b_i ^ c1, ROT_B);
    a_o = a1 + b1 + k1_i;
    d_o = arx_rotr(d1 ^ a_o, ROT_C);
    c_o = c1 + d_o;
    b_o = arx_rotr(b1 ^ c_o, ROT_D);
  end
endmodule

// File: rtl/arx_half_round.sv
module arx_half_round
  import arx_pkg::*;
(
  input  state_t           st_i,
  input  word_t [NWORDS-1:0] msg_i,
  input  logic [3:0]       row_i,
  input  logic             diag_i,
  output state_t           st_o
);
  logic [3:0] idx_a [LANES];
  logic [3:0] idx_b [LANES];
  logic [3:0] idx_c [LANES];
  logic [3:0] idx_d [LANES];
  word_t      ga    [LANES];
  word_t      gb    [LANES];
  word_t      gc    [LANES];
  word_t      gd    [LANES];

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [3:0] s0, s1;
    word_t      k0, k1;

    assign idx_a[j] = 4'(j);
    assign idx_b[j] = diag_i ? 4'(LANES + ((j + 1) % LANES))     : 4'(LANES + j);
    assign idx_c[j] = diag_i ? 4'(2 * LANES + ((j + 2) % LANES)) : 4'(2 * LANES + j);
    assign idx_d[j] = diag_i ? 4'(3 * LANES + ((j + 3) % LANES)) : 4'(3 * LANES + j);

    assign s0 = arx_sched_pick(row_i, {diag_i, 2'(j), 1'b0});
    assign s1 = arx_sched_pick(row_i, {diag_i, 2'(j), 1'b1});
    assign k0 = msg_i[s0] ^ arx_const(s1);
    assign k1 = msg_i[s1] ^ arx_const(s0);

    arx_g_mix u_mix (
      .a_i (st_i[idx_a[j]]),
      .b_i (st_i[idx_b[j]]),
      .c_i (st_i[idx_c[j]]),
      .d_i (st_i[idx_d[j]]),
      .k0_i(k0),
      .k1_i(k1),
      .a_o (ga[j]),
      .b_o (gb[j]),
      .c_o (gc[j]),
      .d_o (gd[j])
    );
  end

  always_comb begin
    st_o = st_i;
    for (int j = 0; j < LANES; j++) begin
      st_o[idx_a[j]] = ga[j];
      st_o[idx_b[j]] = gb[j];
      st_o[idx_c[j]] = gc[j];
      st_o[idx_d[j]] = gd[j];
    end
  end
endmodule

// File: rtl/arx_seq.sv
module arx_seq
  import arx_pkg::*;
#(
  parameter int ROUNDS = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept_i,
  output logic       ready_o,
  output logic       step_o,
  output logic       diag_o,
  output logic       fin_o,
  output logic [3:0] row_o
);
  localparam int RND_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
  localparam logic [RND_W-1:0] LAST_RND = RND_W'(ROUNDS - 1);
  localparam logic [3:0]       LAST_ROW = 4'(SCHED_ROWS - 1);

  seq_state_e       st_q;
  logic [RND_W-1:0] rnd_q;
  logic [3:0]       row_q;
  logic             half_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      rnd_q  <= '0;
      row_q  <= '0;
      half_q <= 1'b0;
    end else begin
      case (st_q)
        SQ_IDLE: begin
          if (accept_i) begin
            st_q   <= SQ_RUN;
            rnd_q  <= '0;
            row_q  <= '0;
            half_q <= 1'b0;
          end
        end
        SQ_RUN: begin
          half_q <= ~half_q;
          if (half_q) begin
            if (rnd_q == LAST_RND) begin
              st_q <= SQ_FIN;
            end else begin
              rnd_q <= rnd_q + 1'b1;
              row_q <= (row_q == LAST_ROW) ? 4'd0 : row_q + 4'd1;
            end
          end
        end
        SQ_FIN:  st_q <= SQ_IDLE;
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign ready_o = (st_q == SQ_IDLE);
  assign step_o  = (st_q == SQ_RUN);
  assign fin_o   = (st_q == SQ_FIN);
  assign diag_o  = half_q;
  assign row_o   = row_q;
endmodule

// File: rtl/arx_cmp_top.sv
module arx_cmp_top
  import arx_pkg::*;
#(
  parameter int ROUNDS = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [255:0] chain_in,
  input  logic [511:0] block_in,
  input  logic [63:0]  count_in,
  input  logic [127:0] salt_in,
  output logic         done,
  output logic [255:0] digest
);
  word_t [CHAIN_W-1:0] chain_w, chain_q, fin_w, digest_q;
  word_t [SALT_W-1:0]  salt_w, salt_q;
  word_t [NWORDS-1:0]  msg_w, msg_q;
  word_t [1:0]         cnt_w;
  state_t              st_q, st_init, st_next;

  logic       accept, step, diag, fin;
  logic [3:0] row;

  assign chain_w = chain_in;
  assign salt_w  = salt_in;
  assign msg_w   = block_in;
  assign cnt_w   = count_in;
  assign accept  = in_valid && in_ready;

  arx_seq #(.ROUNDS(ROUNDS)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept_i(accept),
    .ready_o (in_ready),
    .step_o  (step),
    .diag_o  (diag),
    .fin_o   (fin),
    .row_o   (row)
  );

  arx_half_round u_half (
    .st_i  (st_q),
    .msg_i (msg_q),
    .row_i (row),
    .diag_i(diag),
    .st_o  (st_next)
  );

  // state setup from the incoming job
  always_comb begin
    for (int i = 0; i < CHAIN_W; i++) st_init[i] = chain_w[i];
    for (int i = 0; i < SALT_W; i++)  st_init[CHAIN_W + i] = salt_w[i] ^ arx_const(4'(i));
    st_init[12] = cnt_w[0] ^ arx_const(4'd4);
    st_init[13] = cnt_w[0] ^ arx_const(4'd5);
    st_init[14] = cnt_w[1] ^ arx_const(4'd6);
    st_init[15] = cnt_w[1] ^ arx_const(4'd7);
  end

  // fold the state back into a chaining value
  always_comb begin
    for (int i = 0; i < CHAIN_W; i++)
      fin_w[i] = chain_q[i] ^ salt_q[i % SALT_W] ^ st_q[i] ^ st_q[i + CHAIN_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= '0;
      chain_q  <= '0;
      salt_q   <= '0;
      msg_q    <= '0;
      digest_q <= '0;
      done     <= 1'b0;
    end else begin
      done <= fin;
      if (accept) begin
        st_q    <= st_init;
        chain_q <= chain_w;
        salt_q  <= salt_w;
        msg_q   <= msg_w;
      end else if (step) begin
        st_q <= st_next;
      end
      if (fin) digest_q <= fin_w;
    end
  end

  assign digest = digest_q;
endmodule

// File: rtl/arx_cmp_chk.sv
module arx_cmp_chk #(
  parameter int ROUNDS = 14
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         done,
  input logic [255:0] digest
);
  localparam int LAT = 2 * ROUNDS + 1;
  localparam int CW  = $clog2(LAT + 2);

  logic          trk_busy;
  logic [CW-1:0] trk_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trk_busy <= 1'b0;
      trk_cnt  <= '0;
    end else if (in_valid && in_ready) begin
      trk_busy <= 1'b1;
      trk_cnt  <= '0;
    end else if (done) begin
      trk_busy <= 1'b0;
    end else if (trk_busy) begin
      trk_cnt <= trk_cnt + 1'b1;
    end
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R3
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (trk_busy && trk_cnt == CW'(LAT)));

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R9
  digest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(digest));

  // R11
  ready_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> in_ready);
endmodule

bind arx_cmp_top arx_cmp_chk #(.ROUNDS(ROUNDS)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .done    (done),
  .digest  (digest)
);

// File: tb/arx_cmp_top_tb_top.sv
`timescale 1ns/1ps
module arx_cmp_top_tb_top;
  localparam int ROUNDS = 14;
  localparam int LAT    = 2 * ROUNDS + 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [255:0] chain_in = '0;
  logic [511:0] block_in = '0;
  logic [63:0]  count_in = '0;
  logic [127:0] salt_in = '0;
  logic         done;
  logic [255:0] digest;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [255:0] exp_q[$];
  int           acc_q[$];
  logic [255:0] last_exp = '0;
  int           done_seen = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  arx_cmp_top #(.ROUNDS(ROUNDS)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .chain_in(chain_in), .block_in(block_in), .count_in(count_in), .salt_in(salt_in),
    .done(done), .digest(digest)
  );

  // reference model built from the requirement text
  localparam logic [31:0] KC [16] = '{
    32'h243F6A88, 32'h85A308D3, 32'h13198A2E, 32'h03707344,
    32'hA4093822, 32'h299F31D0, 32'h082EFA98, 32'hEC4E6C89,
    32'h452821E6, 32'h38D01377, 32'hBE5466CF, 32'h34E90C6C,
    32'hC0AC29B7, 32'hC97C50DD, 32'h3F84D5B5, 32'hB5470917};
  localparam logic [63:0] SR [10] = '{
    64'h0123456789ABCDEF, 64'hEA489FD61C02B753, 64'hB8C052FDAE367194,
    64'h7931DCBE265A40F8, 64'h905724AFE1BC683D, 64'h2C6A0B834D75FE19,
    64'hC51FED4A0763928B, 64'hDB7EC13950F4862A, 64'h6FE9B308C2D714A5,
    64'hA2847615FB9E3CD0};
  localparam int QA [8] = '{0, 1, 2, 3, 0, 1, 2, 3};
  localparam int QB [8] = '{4, 5, 6, 7, 5, 6, 7, 4};
  localparam int QC [8] = '{8, 9, 10, 11, 10, 11, 8, 9};
  localparam int QD [8] = '{12, 13, 14, 15, 15, 12, 13, 14};

  function automatic logic [31:0] ror32(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [255:0] ref_model(input logic [255:0] h, input logic [511:0] m,
                                             input logic [63:0] t, input logic [127:0] s);
    logic [31:0] v [16];
    logic [31:0] mw [16];
    logic [255:0] out;
    for (int i = 0; i < 16; i++) mw[i] = m[32*i +: 32];
    for (int i = 0; i < 8; i++) v[i] = h[32*i +: 32];
    for (int i = 0; i < 4; i++) v[8+i] = s[32*i +: 32] ^ KC[i];
    v[12] = t[31:0] ^ KC[4];
    v[13] = t[31:0] ^ KC[5];
    v[14] = t[63:32] ^ KC[6];
    v[15] = t[63:32] ^ KC[7];
    for (int r = 0; r < ROUNDS; r++) begin
      for (int g = 0; g < 8; g++) begin
        int p, q;
        logic [31:0] a, b, c, d;
        p = int'(SR[r % 10][(15 - 2*g) * 4 +: 4]);
        q = int'(SR[r % 10][(14 - 2*g) * 4 +: 4]);
        a = v[QA[g]]; b = v[QB[g]]; c = v[QC[g]]; d = v[QD[g]];
        a = a + b + (mw[p] ^ KC[q]);
        d = ror32(d ^ a, 16);
        c = c + d;
        b = ror32(b ^ c, 12);
        a = a + b + (mw[q] ^ KC[p]);
        d = ror32(d ^ a, 8);
        c = c + d;
        b = ror32(b ^ c, 7);
        v[QA[g]] = a; v[QB[g]] = b; v[QC[g]] = c; v[QD[g]] = d;
      end
    end
    for (int i = 0; i < 8; i++)
      out[32*i +: 32] = h[32*i +: 32] ^ s[32*(i%4) +: 32] ^ v[i] ^ v[i+8];
    return out;
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: offers a job as soon as the core is ready, logs the expectation
  task automatic send(input logic [255:0] h, input logic [511:0] m,
                      input logic [63:0] t, input logic [127:0] s);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    chain_in = h; block_in = m; count_in = t; salt_in = s;
    exp_q.push_back(ref_model(h, m, t, s));
    acc_q.push_back(cyc + 1);
    @(negedge clk);
    in_valid = 1'b0;
    chain_in = '0; block_in = '0; count_in = '0; salt_in = '0;
  endtask

  function automatic logic [511:0] rnd512();
    logic [511:0] r = '0;
    for (int i = 0; i < 16; i++) r = {r[479:0], 32'($urandom())};
    return r;
  endfunction

  // monitor: pops expectations when the core reports a result
  initial begin
    logic prev_done = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (done && prev_done) check(1'b0, "R3 done wider than one cycle", 256'(done), 256'(0));
        if (done) begin
          done_seen++;
          if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected result", digest, '0);
          end else begin
            logic [255:0] e;
            int a;
            e = exp_q.pop_front();
            a = acc_q.pop_front();
            check(digest === e, "R4 R5 R6 R7 R8 digest", digest, e);
            check(cyc - a == LAT, "R3 latency", 256'(cyc - a), 256'(LAT));
            check(in_ready === 1'b1, "R3 ready with done", 256'(in_ready), 256'(1));
            last_exp = e;
          end
        end
        prev_done = done;
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL R3 watchdog actual hung expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [255:0] iv, kat;
    logic [511:0] blk;
    void'($urandom(32'h5eed));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(in_ready === 1'b1, "R1 in_ready", 256'(in_ready), 256'(1));
    check(done === 1'b0, "R1 done", 256'(done), 256'(0));
    check(digest === '0, "R1 digest", digest, '0);

    // R10 known answer, anchors the model too
    iv  = 256'h5BE0CD19_1F83D9AB_9B05688C_510E527F_A54FF53A_3C6EF372_BB67AE85_6A09E667;
    kat = 256'h11139C87_23109E8F_929A74DA_74AE6A41_D4EDB0A7_62DFDED9_4DD7CD8D_0CE8D4EF;
    blk = '0;
    blk[31:0]    = 32'h00800000;
    blk[447:416] = 32'h00000001;
    blk[511:480] = 32'h00000008;
    check(ref_model(iv, blk, 64'd8, '0) === kat, "R10 model known answer", ref_model(iv, blk, 64'd8, '0), kat);
    send(iv, blk, 64'd8, '0);
    wait (exp_q.size() == 0);
    @(negedge clk);
    check(digest === kat, "R10 known answer", digest, kat);

    // several patterns, both counter words and salt non-zero (R4 R7 R8)
    for (int k = 0; k < 4; k++)
      send(rnd512()[255:0], rnd512(), {32'($urandom()), 32'($urandom())}, rnd512()[127:0]);
    // all-ones corner
    send('1, '1, '1, '1);
    wait (exp_q.size() == 0);

    // R9 hold after done
    repeat (7) @(negedge clk);
    check(digest === last_exp, "R9 digest hold", digest, last_exp);
    check(done === 1'b0, "R9 done low while idle", 256'(done), 256'(0));

    // R2 valid and data during busy are ignored
    send(rnd512()[255:0], rnd512(), 64'h1234_5678_9ABC_DEF0, rnd512()[127:0]);
    for (int k = 0; k < 10; k++) begin
      in_valid = 1'b1;
      chain_in = rnd512()[255:0]; block_in = rnd512(); salt_in = rnd512()[127:0];
      count_in = {32'($urandom()), 32'($urandom())};
      @(negedge clk);
      check(in_ready === 1'b0, "R2 busy not ready", 256'(in_ready), 256'(0));
    end
    in_valid = 1'b0;
    wait (exp_q.size() == 0);
    repeat (40) @(negedge clk);
    check(done_seen == 7, "R2 one result per accepted job", 256'(done_seen), 256'(7));

    // R11 back to back jobs
    for (int k = 0; k < 3; k++)
      send(rnd512()[255:0], rnd512(), {32'($urandom()), 32'($urandom())}, rnd512()[127:0]);
    wait (exp_q.size() == 0);
    repeat (3) @(negedge clk);
    check(done_seen == 10, "R11 back to back results", 256'(done_seen), 256'(10));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule